// File: doc/BRIEF.md
# E1 Receive Spare-Bit Capture

This block sits behind the frame aligner of an E1 receiver. It looks only at timeslot 0 and pulls out the bits that carry national use, the remote alarm and the CRC-4 international bits. It presents them to a host in two views, and both run all the time. The first view is a double-frame snapshot: the byte of the most recent frame-alignment frame together with the byte of the non-alignment frame that came just before it. The second view is a set of eight registers for each CRC-4 multiframe. In that set each register holds one spare-bit position as it was seen across eight frames.

Serial data arrives one bit per cycle in which `rx_valid` is high. The block has no ready output and never stalls the stream, so the upstream aligner needs no back-pressure logic. A beat offered with `rx_valid` high is always taken. The flags for frame type and multiframe start come with the timeslot 0 bits. When either view is refreshed, a latched status bit is set. A host reads that bit through a registered address/data port, and reading the status address clears it. Frame alignment search and CRC-4 checking happen elsewhere.

Top module: `e1_spare_bit_rx`

## Requirements
- R1: After reset, every host-visible register reads 0, both status flags read 0, and `rd_data` is 0.
- R2: A bit is taken only in a cycle where `rx_valid` and `rx_ts0` are both high. Eight such beats make one timeslot 0 byte, and the first bit taken lands in bit 7. Cycles with `rx_valid` low inside timeslot 0 are skipped, and so are all bits with `rx_ts0` low.
- R3: When the eighth bit of a byte arrives with `rx_fas`=1, the double-frame pair is refreshed one cycle later. The alignment register (address 1) takes that byte unchanged. The non-alignment register (address 2) takes the latest byte that arrived with `rx_fas`=0, also unchanged.
- R4: The same event sets status bit 0 (double-frame updated).
- R5: A byte whose first bit arrives with `rx_mf_start`=1 is frame 0 of a multiframe. The multiframe set is committed when the byte that is frame 15 completes. No commit happens before the first `rx_mf_start` after reset.
- R6: Each multiframe register holds eight bits with the earliest frame in bit 7. Address 3 holds Si (byte bit 7) of the alignment frames. Address 4 holds Si of the non-alignment frames. Address 5 holds the A bit (byte bit 5) of the non-alignment frames. Addresses 6 to 10 hold Sa4 to Sa8, which are byte bits 4 down to 0 of the non-alignment frames. All eight registers change together in one cycle and hold their values between commits.
- R7: A multiframe commit sets status bit 1 (multiframe updated).
- R8: A read of address 0 returns both flags and then clears them. A flag set in the same cycle as the clear stays set.
- R9: A read with `rd_en` high returns data on `rd_data` at the next clock edge. Addresses 11 to 15 read as 0.
- R10: A byte that completes with `rx_fas`=0 does not change the double-frame pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial receive data bit |
| rx_valid | input | 1 | Bit enable, high when `rx_bit` is valid |
| rx_ts0 | input | 1 | High while the bits belong to timeslot 0 |
| rx_fas | input | 1 | 1 = frame-alignment frame, 0 = non-alignment frame |
| rx_mf_start | input | 1 | Marks frame 0 of a CRC-4 multiframe, sampled with the first bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Registered read data |

## Verification
The stream places idle beats inside timeslot 0 and filler bits outside it. A design that took those beats would shift every later byte. Three frames arrive before the first multiframe marker. A design that committed with no sync, or counted frames from reset, would raise the multiframe flag too early or load mixed frames into the set. A status read is issued in the very cycle that the multiframe flag is set. A design that let the clear win would lose that event. The bench also reads the double-frame pair just after a non-alignment frame, so a design that refreshed the pair on every frame would show the newer byte.

// File: rtl/e1sb_pkg.sv
package e1sb_pkg;
  localparam int BYTE_W    = 8;
  localparam int MF_FRAMES = 16;
  localparam int ADDR_W    = 4;
  localparam int SA_N      = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 4'd0,
    A_FAS    = 4'd1,
    A_NFAS   = 4'd2,
    A_SI_F   = 4'd3,
    A_SI_N   = 4'd4,
    A_REM    = 4'd5,
    A_SA4    = 4'd6,
    A_SA8    = 4'd10
  } reg_addr_e;

  typedef struct packed {
    logic [BYTE_W-1:0]           si_f;
    logic [BYTE_W-1:0]           si_n;
    logic [BYTE_W-1:0]           rem;
    logic [SA_N-1:0][BYTE_W-1:0] sa;   // sa[0] = Sa4 ... sa[4] = Sa8
  } mf_set_t;
endpackage

// File: rtl/e1sb_ts0_deser.sv
module e1sb_ts0_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_bit,
  input  logic         rx_valid,
  input  logic         rx_ts0,
  input  logic         rx_fas,
  input  logic         rx_mf_start,
  output logic [W-1:0] byte_q,
  output logic         done_q,
  output logic         fas_q,
  output logic         mfh_q
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;
  logic          mf_hit;
  logic          beat, last;

  assign beat = rx_valid && rx_ts0;
  assign last = beat && (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      mf_hit <= 1'b0;
      byte_q <= '0;
      done_q <= 1'b0;
      fas_q  <= 1'b0;
      mfh_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!rx_ts0) begin
        cnt <= '0;
      end else if (beat) begin
        cnt <= last ? '0 : cnt + 1'b1;
        sh  <= {sh[W-3:0], rx_bit};
        if (cnt == '0) mf_hit <= rx_mf_start;
        if (last) begin
          byte_q <= {sh, rx_bit};
          done_q <= 1'b1;
          fas_q  <= rx_fas;
          mfh_q  <= (cnt == '0) ? rx_mf_start : mf_hit;
        end
      end
    end
  end
endmodule

// File: rtl/e1sb_dbl_frame.sv
module e1sb_dbl_frame #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic         fas,
  input  logic [W-1:0] byte_in,
  output logic [W-1:0] fas_vis,
  output logic [W-1:0] nfas_vis,
  output logic         upd
);
  logic [W-1:0] nfas_last;

  assign upd = done && fas;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nfas_last <= '0;
      fas_vis   <= '0;
      nfas_vis  <= '0;
    end else if (done) begin
      if (fas) begin
        fas_vis  <= byte_in;
        nfas_vis <= nfas_last;
      end else begin
        nfas_last <= byte_in;
      end
    end
  end
endmodule

// File: rtl/e1sb_mf_gather.sv
module e1sb_mf_gather
  import e1sb_pkg::*;
#(
  parameter int W      = BYTE_W,
  parameter int FRAMES = MF_FRAMES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done,
  input  logic           fas,
  input  logic           mfh,
  input  logic [W-2:0]   spare,   // {Si, A, Sa4..Sa8}
  output mf_set_t        mf_vis,
  output logic           commit
);
  localparam int FW = $clog2(FRAMES);

  logic [FW-1:0] fidx;
  logic          synced;
  mf_set_t       shd, shd_nx;
  logic          take_f, take_n;

  assign take_f = done && fas;
  assign take_n = done && !fas;
  assign commit = done && synced && !mfh && (fidx == FW'(FRAMES-1));

  always_comb begin
    shd_nx      = shd;
    shd_nx.si_f = take_f ? {shd.si_f[W-2:0], spare[W-2]} : shd.si_f;
    shd_nx.si_n = take_n ? {shd.si_n[W-2:0], spare[W-2]} : shd.si_n;
    shd_nx.rem  = take_n ? {shd.rem[W-2:0],  spare[W-3]} : shd.rem;
  end

  for (genvar g = 0; g < SA_N; g++) begin : g_sa
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd.sa[g]    <= '0;
        mf_vis.sa[g] <= '0;
      end else begin
        if (take_n) shd.sa[g] <= {shd.sa[g][W-2:0], spare[SA_N-1-g]};
        if (commit) mf_vis.sa[g] <= take_n ? {shd.sa[g][W-2:0], spare[SA_N-1-g]}
                                           : shd.sa[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fidx        <= '0;
      synced      <= 1'b0;
      shd.si_f    <= '0;
      shd.si_n    <= '0;
      shd.rem     <= '0;
      mf_vis.si_f <= '0;
      mf_vis.si_n <= '0;
      mf_vis.rem  <= '0;
    end else begin
      shd.si_f <= shd_nx.si_f;
      shd.si_n <= shd_nx.si_n;
      shd.rem  <= shd_nx.rem;
      if (done) begin
        if (mfh) begin
          fidx   <= FW'(1);
          synced <= 1'b1;
        end else begin
          fidx <= fidx + 1'b1;
        end
      end
      if (commit) begin
        mf_vis.si_f <= shd_nx.si_f;
        mf_vis.si_n <= shd_nx.si_n;
        mf_vis.rem  <= shd_nx.rem;
      end
    end
  end
endmodule

// File: rtl/e1sb_host_if.sv
module e1sb_host_if
  import e1sb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              df_upd,
  input  logic              mf_upd,
  input  logic [BYTE_W-1:0] fas_vis,
  input  logic [BYTE_W-1:0] nfas_vis,
  input  mf_set_t           mf_vis,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              df_flag,
  output logic              mf_flag
);
  logic              clr;
  logic [BYTE_W-1:0] mux;

  assign clr = rd_en && (rd_addr == A_STATUS);

  always_comb begin
    mux = '0;
    if (rd_addr == A_STATUS)    mux = {{(BYTE_W-2){1'b0}}, mf_flag, df_flag};
    else if (rd_addr == A_FAS)  mux = fas_vis;
    else if (rd_addr == A_NFAS) mux = nfas_vis;
    else if (rd_addr == A_SI_F) mux = mf_vis.si_f;
    else if (rd_addr == A_SI_N) mux = mf_vis.si_n;
    else if (rd_addr == A_REM)  mux = mf_vis.rem;
    else if (rd_addr >= A_SA4 && rd_addr <= A_SA8)
      mux = mf_vis.sa[rd_addr - A_SA4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      df_flag <= 1'b0;
      mf_flag <= 1'b0;
      rd_data <= '0;
    end else begin
      if (df_upd)   df_flag <= 1'b1;
      else if (clr) df_flag <= 1'b0;
      if (mf_upd)   mf_flag <= 1'b1;
      else if (clr) mf_flag <= 1'b0;
      if (rd_en) rd_data <= mux;
    end
  end
endmodule

// File: rtl/e1_spare_bit_rx.sv
module e1_spare_bit_rx
  import e1sb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_valid,
  input  logic              rx_ts0,
  input  logic              rx_fas,
  input  logic              rx_mf_start,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] b_byte;
  logic              b_done, b_fas, b_mfh;
  logic [BYTE_W-1:0] fas_vis, nfas_vis;
  logic              df_upd, mf_commit, df_flag, mf_flag;
  mf_set_t           mf_vis;

  e1sb_ts0_deser #(.W(BYTE_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .rx_ts0(rx_ts0), .rx_fas(rx_fas), .rx_mf_start(rx_mf_start),
    .byte_q(b_byte), .done_q(b_done), .fas_q(b_fas), .mfh_q(b_mfh)
  );

  e1sb_dbl_frame #(.W(BYTE_W)) u_dbl (
    .clk(clk), .rst_n(rst_n), .done(b_done), .fas(b_fas), .byte_in(b_byte),
    .fas_vis(fas_vis), .nfas_vis(nfas_vis), .upd(df_upd)
  );

  e1sb_mf_gather #(.W(BYTE_W), .FRAMES(MF_FRAMES)) u_mf (
    .clk(clk), .rst_n(rst_n), .done(b_done), .fas(b_fas), .mfh(b_mfh),
    .spare({b_byte[BYTE_W-1], b_byte[BYTE_W-3:0]}),
    .mf_vis(mf_vis), .commit(mf_commit)
  );

  e1sb_host_if u_host (
    .clk(clk), .rst_n(rst_n), .df_upd(df_upd), .mf_upd(mf_commit),
    .fas_vis(fas_vis), .nfas_vis(nfas_vis), .mf_vis(mf_vis),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .df_flag(df_flag), .mf_flag(mf_flag)
  );
endmodule

// File: rtl/e1sb_chk.sv
module e1sb_chk
  import e1sb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              fas,
  input logic              df_flag,
  input logic              mf_flag,
  input logic              mf_commit,
  input logic [BYTE_W-1:0] fas_vis,
  input mf_set_t           mf_vis,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data
);
  // R4
  df_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fas) |=> df_flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_STATUS && !(done && fas)) |=> !df_flag);
  // R7
  mf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_commit |=> mf_flag);
  // R10
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fas) |=> $stable(fas_vis));
  // R6
  mf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_commit |=> $stable(mf_vis));
  // R9
  unused_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr > A_SA8) |=> rd_data == '0);
endmodule

bind e1_spare_bit_rx e1sb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(b_done), .fas(b_fas),
  .df_flag(df_flag), .mf_flag(mf_flag), .mf_commit(mf_commit),
  .fas_vis(fas_vis), .mf_vis(mf_vis),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_e1_spare_bit_rx.sv
module sim_e1_spare_bit_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_valid = 1'b0, rx_ts0 = 1'b0, rx_fas = 1'b0, rx_mf_start = 1'b0;
  logic rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] last_nfas = 8'h00;
  logic [7:0] end_rd = 8'h00;

  always #10 clk = ~clk;

  e1_spare_bit_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .rx_ts0(rx_ts0), .rx_fas(rx_fas), .rx_mf_start(rx_mf_start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int m, int k);
    return 8'((m * 37 + k * 91 + 13) & 8'hFF);
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic filler();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_ts0 = 1'b0; rx_valid = 1'b1; rx_bit = i[0];
      rx_fas = ~rx_fas; rx_mf_start = 1'b1;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_mf_start = 1'b0;
  endtask

  // R2: idle beat inside timeslot 0 carries an inverted bit that must be skipped
  task automatic send_byte(logic [7:0] b, logic fas, logic mf, logic rd_now);
    filler();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 4) begin
        rx_ts0 = 1'b1; rx_valid = 1'b0; rx_bit = ~b[7-i]; rx_mf_start = 1'b1;
        @(negedge clk);
      end
      rx_ts0 = 1'b1; rx_valid = 1'b1; rx_bit = b[7-i];
      rx_fas = fas; rx_mf_start = (i == 0) ? mf : 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_ts0 = 1'b0; rx_mf_start = 1'b0;
    if (rd_now) begin rd_en = 1'b1; rd_addr = 4'd0; end
    @(negedge clk);
    if (rd_now) begin end_rd = rd_data; rd_en = 1'b0; end
    repeat (2) @(negedge clk);
    if (!fas) last_nfas = b;
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] e_sif, e_sin, e_rem;
    logic [4:0][7:0] e_sa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d);
      chk(d, 8'h00, $sformatf("R1 reset addr %0d", a));
    end
    rd(4'd12, d); chk(d, 8'h00, "R9 unused addr 12 after reset");

    // R5: frames before any multiframe marker must not commit
    for (int k = 0; k < 3; k++) begin
      send_byte(pat(9, k), (k % 2) == 0, 1'b0, 1'b0);
      rd(4'd0, d);
      chk(d, ((k % 2) == 0) ? 8'h01 : 8'h00, $sformatf("R5 R4 status pre-sync frame %0d", k));
    end

    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] b;
        b = pat(m, k);
        send_byte(b, (k % 2) == 0, k == 0, (m == 2 && k == 15));
        if ((k % 2) == 0) begin
          rd(4'd0, d); chk(d, 8'h01, $sformatf("R4 status after aligned m%0d k%0d", m, k));
          rd(4'd0, d); chk(d, 8'h00, $sformatf("R8 status cleared m%0d k%0d", m, k));
          rd(4'd1, d); chk(d, b, $sformatf("R3 aligned byte m%0d k%0d", m, k));
          rd(4'd2, d);
          chk(d, (k == 0 && m == 0) ? pat(9, 1) : pat(m == 0 || k > 0 ? m : m - 1, k == 0 ? 15 : k - 1),
              $sformatf("R3 paired byte m%0d k%0d", m, k));
        end else if (k == 1) begin
          rd(4'd1, d); chk(d, pat(m, 0), $sformatf("R10 pair held after non-aligned m%0d", m));
          rd(4'd2, d);
          chk(d, (m == 0) ? pat(9, 1) : pat(m - 1, 15), $sformatf("R10 paired byte held m%0d", m));
        end else if (k < 15) begin
          rd(4'd0, d); chk(d, 8'h00, $sformatf("R5 no early commit m%0d k%0d", m, k));
        end
      end
      if (m == 2) begin
        chk(end_rd, 8'h00, "R8 read in set cycle returns prior flags");
      end
      rd(4'd0, d); chk(d, 8'h02, $sformatf("R7 R8 multiframe flag m%0d", m));
      e_sif = '0; e_sin = '0; e_rem = '0; e_sa = '0;
      for (int j = 0; j < 8; j++) begin
        e_sif[7-j] = pat(m, 2*j)[7];
        e_sin[7-j] = pat(m, 2*j+1)[7];
        e_rem[7-j] = pat(m, 2*j+1)[5];
        for (int g = 0; g < 5; g++) e_sa[g][7-j] = pat(m, 2*j+1)[4-g];
      end
      rd(4'd3, d); chk(d, e_sif, $sformatf("R6 Si aligned m%0d", m));
      rd(4'd4, d); chk(d, e_sin, $sformatf("R6 Si non-aligned m%0d", m));
      rd(4'd5, d); chk(d, e_rem, $sformatf("R6 A bits m%0d", m));
      for (int g = 0; g < 5; g++) begin
        rd(4'(6 + g), d); chk(d, e_sa[g], $sformatf("R6 Sa%0d m%0d", g + 4, m));
      end
    end
    rd(4'd15, d); chk(d, 8'h00, "R9 unused addr 15");
    rd(4'd11, d); chk(d, 8'h00, "R9 unused addr 11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule